// File: doc/BRIEF.md
# Pipelined CORDIC Vector Rotator

This block rotates a two-dimensional fixed-point vector by an angle. It takes the coordinates `x_in` and `y_in` and an angle `ang_in` given in radians. It returns the rotated coordinates on `x_out` and `y_out`. The rotation is computed by a fully unrolled chain of shift-and-add micro-rotations. A new vector can enter on every enabled clock, and each result appears a fixed number of enabled clocks later.

Before the micro-rotations start, the angle is folded into the half plane where the iteration converges. Without compensation, the outputs carry the iteration gain K ≈ 1.6467602, so the result is a similarity rotation. With compensation on, a constant multiply by 1/K restores unit gain. Both outputs are rounded to nearest at the selected output fraction width.

The parameters are:
- `FRAC_IN` (F): the fraction width shared by the coordinates and the angle.
- `FRAC_OUT`: the output fraction width.
- `SIGNED_IO`: signed or unsigned inputs.
- `COMPENSATE`: gain compensation on or off.
- `GUARD`: extra internal fraction bits.

Top module: `cordic_rotator`

## Requirements
- R1: With `SIGNED_IO`=1, `x_in` and `y_in` are two's complement values of width F+2 with F fraction bits, covering [−1,1]. `ang_in` is two's complement of width F+3 with F fraction bits, in radians over [−π,+π].
- R2: With `COMPENSATE`=0, `x_out` is within 1 output LSB of K·(x·cos a − y·sin a), and `y_out` is within 1 output LSB of K·(x·sin a + y·cos a), where K = 1.6467602. Both outputs are signed, with width `FRAC_OUT`+3 and `FRAC_OUT` fraction bits.
- R3: With `COMPENSATE`=1, the outputs are signed with width `FRAC_OUT`+2 and lie within 1 output LSB of the unit-gain rotation x·cos a − y·sin a and x·sin a + y·cos a.
- R4: Angles with magnitude above π/2, up to and including the codes nearest to ±π, meet the same accuracy as R2 and R3.
- R5: The corner inputs (±1, ±1) at any angle produce in-range outputs with the accuracy of R2 and R3, and no wrap-around.
- R6: A result appears exactly max(`FRAC_IN`,`FRAC_OUT`)+`GUARD`+2 enabled clocks after its inputs are sampled. Both coordinates appear on the same clock. Vectors applied on consecutive clocks come out on consecutive clocks.
- R7: While `en` is low, nothing in the pipeline advances and the outputs hold their values. Once `en` returns high, processing resumes.
- R8: The reset `rst_n` is synchronous and active low. A clock edge with `rst_n` low clears both outputs to zero.
- R9: With `SIGNED_IO`=0, `x_in` and `y_in` are unsigned with width F+1 over [0,1], and `ang_in` is unsigned with width F+2 over [0,π]. The outputs stay signed and meet R2.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en | input | 1 | Pipeline advance enable |
| x_in | input | F+2 signed / F+1 unsigned | X coordinate |
| y_in | input | F+2 signed / F+1 unsigned | Y coordinate |
| ang_in | input | F+3 signed / F+2 unsigned | Rotation angle in radians, F fraction bits |
| x_out | output | FRAC_OUT+3, or FRAC_OUT+2 compensated | Rotated X coordinate |
| y_out | output | FRAC_OUT+3, or FRAC_OUT+2 compensated | Rotated Y coordinate |

## Verification
Each result is due exactly max(F,FRAC_OUT)+GUARD+2 enabled rising edges after its inputs are applied; with the bench parameters this is 19 edges. The bench applies inputs on a falling edge, counts that many rising edges, and samples on the following falling edge. A streaming test samples one edge early to confirm that the earlier, flushed result is still present, then checks three back-to-back vectors on three consecutive edges. Reset is checked one edge after `rst_n` falls. The enable test holds `en` low for many edges and then allows the full latency again after it rises.

// File: rtl/cordic_rot_pkg.sv
`timescale 1ns/1ps
// Package: cordic_rot_pkg
// Constant helpers for the rotator. They compute the fixed-point micro-rotation
// angles, the value of pi and the inverse iteration gain at elaboration time.
// Assumes fw stays at or below 50, so that the real arithmetic is exact enough.
package cordic_rot_pkg;

    // 2.0 raised to a non-negative integer power
    function automatic real pow2(input int e);
        real p;
        p = 1.0;
        for (int k = 0; k < e; k++) p = p * 2.0;
        return p;
    endfunction

    // arctangent of 2^-idx in radians, by power series (t <= 0.5 for idx >= 1)
    function automatic real atan_pow2(input int idx);
        real t, term, acc;
        if (idx == 0) return 0.78539816339744830962;
        t = 1.0 / pow2(idx);
        acc = 0.0;
        term = t;
        for (int m = 0; m < 40; m++) begin
            if (m % 2 == 0) acc = acc + term / real'(2 * m + 1);
            else            acc = acc - term / real'(2 * m + 1);
            term = term * t * t;
        end
        return acc;
    endfunction

    // square root by Newton iteration, for arguments >= 1
    function automatic real sqrt_nr(input real v);
        real r;
        r = v;
        for (int k = 0; k < 40; k++) r = 0.5 * (r + v / r);
        return r;
    endfunction

    // micro-rotation angle for stage idx, scaled by 2^fw and rounded
    function automatic longint atan_fix(input int idx, input int fw);
        return longint'(atan_pow2(idx) * pow2(fw));
    endfunction

    // pi scaled by 2^fw and rounded
    function automatic longint pi_fix(input int fw);
        return longint'(3.14159265358979323846 * pow2(fw));
    endfunction

    // 1/K for n stages, scaled by 2^fw and rounded
    function automatic longint inv_gain_fix(input int n, input int fw);
        real g;
        g = 1.0;
        for (int i = 0; i < n; i++) g = g * sqrt_nr(1.0 + 1.0 / pow2(2 * i));
        return longint'(pow2(fw) / g);
    endfunction

endpackage

// File: rtl/cordic_rot_fold.sv
`timescale 1ns/1ps
// Module: cordic_rot_fold
// Widens the inputs to the internal format: coordinates get FW fraction bits,
// and the angle gets FW fraction bits in radians. An angle beyond +-pi/2 is
// brought back by +-pi, and the vector is negated to match. The result is
// registered. Assumes FW >= FRAC_IN and enough headroom in DW and AW for +-pi.
module cordic_rot_fold #(
    parameter int FRAC_IN   = 12,
    parameter int SIGNED_IO = 1,
    parameter int FW        = 17,
    parameter int DW        = 21,
    parameter int AW        = 21,
    parameter int XW        = 14,
    parameter int AIW       = 15
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic [XW-1:0]        x_in,
    input  logic [XW-1:0]        y_in,
    input  logic [AIW-1:0]       a_in,
    output logic signed [DW-1:0] x_o,
    output logic signed [DW-1:0] y_o,
    output logic signed [AW-1:0] z_o
);
    localparam int SH = FW - FRAC_IN;
    localparam logic signed [AW-1:0] PI_C      = AW'(cordic_rot_pkg::pi_fix(FW));
    localparam logic signed [AW-1:0] HALF_PI_C = AW'(cordic_rot_pkg::pi_fix(FW - 1));
    localparam logic signed [AW-1:0] Z_LIM     = HALF_PI_C + AW'(2);

    logic signed [DW-1:0] x_ext, y_ext, x_f, y_f;
    logic signed [AW-1:0] z_ext, z_f;

    generate
        if (SIGNED_IO != 0) begin : g_signed_in
            assign x_ext = $signed({{(DW-XW){x_in[XW-1]}}, x_in}) <<< SH;
            assign y_ext = $signed({{(DW-XW){y_in[XW-1]}}, y_in}) <<< SH;
            assign z_ext = $signed({{(AW-AIW){a_in[AIW-1]}}, a_in}) <<< SH;
        end else begin : g_unsigned_in
            assign x_ext = $signed({{(DW-XW){1'b0}}, x_in}) <<< SH;
            assign y_ext = $signed({{(DW-XW){1'b0}}, y_in}) <<< SH;
            assign z_ext = $signed({{(AW-AIW){1'b0}}, a_in}) <<< SH;
        end
    endgenerate

    // fold the angle into [-pi/2, +pi/2] and negate the vector to match
    always_comb begin
        x_f = x_ext;
        y_f = y_ext;
        z_f = z_ext;
        if (z_ext > HALF_PI_C) begin
            x_f = -x_ext;
            y_f = -y_ext;
            z_f = z_ext - PI_C;
        end else if (z_ext < -HALF_PI_C) begin
            x_f = -x_ext;
            y_f = -y_ext;
            z_f = z_ext + PI_C;
        end
    end

    // register the folded vector and angle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else if (en) begin
            x_o <= x_f;
            y_o <= y_f;
            z_o <= z_f;
        end
    end

    AST_FOLD_RANGE: assert property (@(posedge clk) disable iff (!rst_n)
        (z_o <= Z_LIM) && (z_o >= -Z_LIM)); // R4

endmodule

// File: rtl/cordic_rot_stage.sv
`timescale 1ns/1ps
// Module: cordic_rot_stage
// One registered micro-rotation, number IDX. It rotates the vector by
// +-atan(2^-IDX), picking the direction that drives the residual angle toward
// zero. Assumes the residual angle at the input is within the convergence range.
module cordic_rot_stage #(
    parameter int DW  = 21,
    parameter int AW  = 21,
    parameter int FW  = 17,
    parameter int IDX = 0
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    input  logic signed [AW-1:0] z_i,
    output logic signed [DW-1:0] x_o,
    output logic signed [DW-1:0] y_o,
    output logic signed [AW-1:0] z_o
);
    localparam logic signed [AW-1:0] STEP_ANG = AW'(cordic_rot_pkg::atan_fix(IDX, FW));
    localparam logic signed [AW-1:0] Z_BOUND  = (STEP_ANG <<< 1) + AW'(32);

    logic signed [DW-1:0] x_sh, y_sh;
    logic                 turn_pos;

    assign x_sh     = x_i >>> IDX;
    assign y_sh     = y_i >>> IDX;
    assign turn_pos = ~z_i[AW-1];

    // apply one shift-add rotation step and update the residual angle
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
            z_o <= '0;
        end else if (en) begin
            if (turn_pos) begin
                x_o <= x_i - y_sh;
                y_o <= y_i + x_sh;
                z_o <= z_i - STEP_ANG;
            end else begin
                x_o <= x_i + y_sh;
                y_o <= y_i - x_sh;
                z_o <= z_i + STEP_ANG;
            end
        end
    end

    AST_RESIDUAL_SHRINKS: assert property (@(posedge clk) disable iff (!rst_n)
        (z_o <= Z_BOUND) && (z_o >= -Z_BOUND)); // R2

endmodule

// File: rtl/cordic_rot_post.sv
`timescale 1ns/1ps
// Module: cordic_rot_post
// Output stage. When COMPENSATE is set it multiplies both coordinates by 1/K.
// It then rounds to nearest at FRAC_OUT fraction bits and registers the
// OW-bit signed result. Assumes FW > FRAC_OUT.
module cordic_rot_post #(
    parameter int DW         = 21,
    parameter int FW         = 17,
    parameter int NSTG       = 17,
    parameter int FRAC_OUT   = 10,
    parameter int COMPENSATE = 0,
    parameter int OW         = 13
) (
    input  logic                 clk,
    input  logic                 rst_n,
    input  logic                 en,
    input  logic signed [DW-1:0] x_i,
    input  logic signed [DW-1:0] y_i,
    output logic [OW-1:0]        x_o,
    output logic [OW-1:0]        y_o
);
    localparam int PW = DW + FW + 2;
    localparam int SH = (COMPENSATE != 0) ? (2 * FW - FRAC_OUT) : (FW - FRAC_OUT);
    localparam logic signed [PW-1:0] RND = PW'(1) <<< (SH - 1);

    logic signed [PW-1:0] x_w, y_w, x_s, y_s, x_r, y_r;

    assign x_w = {{(PW-DW){x_i[DW-1]}}, x_i};
    assign y_w = {{(PW-DW){y_i[DW-1]}}, y_i};

    generate
        if (COMPENSATE != 0) begin : g_comp
            localparam logic signed [PW-1:0] INV_K = PW'(cordic_rot_pkg::inv_gain_fix(NSTG, FW));
            assign x_s = x_w * INV_K;
            assign y_s = y_w * INV_K;
        end else begin : g_raw
            assign x_s = x_w;
            assign y_s = y_w;
        end
    endgenerate

    assign x_r = (x_s + RND) >>> SH;
    assign y_r = (y_s + RND) >>> SH;

    // register the rounded outputs together
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            x_o <= '0;
            y_o <= '0;
        end else if (en) begin
            x_o <= x_r[OW-1:0];
            y_o <= y_r[OW-1:0];
        end
    end

    AST_NO_OVERFLOW_X: assert property (@(posedge clk) disable iff (!rst_n)
        (&x_r[PW-1:OW-1]) || !(|x_r[PW-1:OW-1])); // R5
    AST_NO_OVERFLOW_Y: assert property (@(posedge clk) disable iff (!rst_n)
        (&y_r[PW-1:OW-1]) || !(|y_r[PW-1:OW-1])); // R5

endmodule

// File: rtl/cordic_rotator.sv
`timescale 1ns/1ps
// Module: cordic_rotator
// Top of the pipelined rotator. The chain is a fold register, then NSTG
// micro-rotation stages, then the scale-and-round register. Latency is
// NSTG+2 enabled clocks. Assumes a synchronous active-low reset and
// FRAC_IN, FRAC_OUT >= 1.
module cordic_rotator #(
    parameter int FRAC_IN    = 12,
    parameter int FRAC_OUT   = 10,
    parameter int SIGNED_IO  = 1,
    parameter int COMPENSATE = 0,
    parameter int GUARD      = 5
) (
    input  logic                                                         clk,
    input  logic                                                         rst_n,
    input  logic                                                         en,
    input  logic [((SIGNED_IO != 0) ? FRAC_IN + 2 : FRAC_IN + 1)-1:0]    x_in,
    input  logic [((SIGNED_IO != 0) ? FRAC_IN + 2 : FRAC_IN + 1)-1:0]    y_in,
    input  logic [((SIGNED_IO != 0) ? FRAC_IN + 3 : FRAC_IN + 2)-1:0]    ang_in,
    output logic [((COMPENSATE != 0) ? FRAC_OUT + 2 : FRAC_OUT + 3)-1:0] x_out,
    output logic [((COMPENSATE != 0) ? FRAC_OUT + 2 : FRAC_OUT + 3)-1:0] y_out
);
    localparam int XW   = (SIGNED_IO != 0) ? FRAC_IN + 2 : FRAC_IN + 1;
    localparam int AIW  = (SIGNED_IO != 0) ? FRAC_IN + 3 : FRAC_IN + 2;
    localparam int OW   = (COMPENSATE != 0) ? FRAC_OUT + 2 : FRAC_OUT + 3;
    localparam int FW   = ((FRAC_IN > FRAC_OUT) ? FRAC_IN : FRAC_OUT) + GUARD;
    localparam int NSTG = FW;
    localparam int DW   = FW + 4;
    localparam int AW   = FW + 4;

    logic signed [DW-1:0] x_p [0:NSTG];
    logic signed [DW-1:0] y_p [0:NSTG];
    logic signed [AW-1:0] z_p [0:NSTG];

    cordic_rot_fold #(
        .FRAC_IN(FRAC_IN), .SIGNED_IO(SIGNED_IO), .FW(FW),
        .DW(DW), .AW(AW), .XW(XW), .AIW(AIW)
    ) u_fold (
        .clk(clk), .rst_n(rst_n), .en(en),
        .x_in(x_in), .y_in(y_in), .a_in(ang_in),
        .x_o(x_p[0]), .y_o(y_p[0]), .z_o(z_p[0])
    );

    generate
        for (genvar k = 0; k < NSTG; k++) begin : g_stage
            cordic_rot_stage #(.DW(DW), .AW(AW), .FW(FW), .IDX(k)) u_stage (
                .clk(clk), .rst_n(rst_n), .en(en),
                .x_i(x_p[k]), .y_i(y_p[k]), .z_i(z_p[k]),
                .x_o(x_p[k+1]), .y_o(y_p[k+1]), .z_o(z_p[k+1])
            );
        end
    endgenerate

    cordic_rot_post #(
        .DW(DW), .FW(FW), .NSTG(NSTG), .FRAC_OUT(FRAC_OUT),
        .COMPENSATE(COMPENSATE), .OW(OW)
    ) u_post (
        .clk(clk), .rst_n(rst_n), .en(en),
        .x_i(x_p[NSTG]), .y_i(y_p[NSTG]),
        .x_o(x_out), .y_o(y_out)
    );

    AST_HOLD_WHEN_IDLE: assert property (@(posedge clk) disable iff (!rst_n)
        (rst_n && !en) |=> ($stable(x_out) && $stable(y_out))); // R7

endmodule

// File: tb/cordic_rotator_tb.sv
`timescale 1ns/1ps
// Bench for cordic_rotator. It runs three instances on the same vectors:
// signed with gain, signed compensated, and unsigned with gain.
module cordic_rotator_tb;
    localparam int  F   = 12;
    localparam int  FO  = 10;
    localparam int  LAT = F + 5 + 2;          // R6: max(F,FO)+GUARD+2
    localparam real KG  = 1.6467602;
    localparam real ONE = 4096.0;
    localparam real OSC = 1024.0;
    localparam int  NV  = 12;
    localparam int VX [NV] = '{4096, 4096,    0, 4096, -4096,  4096, -4096, 2048, -1500,  4096, -4096,  1234};
    localparam int VY [NV] = '{   0,    0, 4096, 4096, -4096, -4096,  4096, 1024,  3000,  4096,  4096, -2345};
    localparam int VA [NV] = '{   0, 3217, 6434, 3217, -3217, 12868,-12868, 9000, -9000, -6434,   100,  5000};

    logic clk = 1'b0;
    always #2.5 clk = ~clk;

    logic rst_n, en;
    logic signed [13:0] xs, ys;
    logic signed [14:0] as;
    logic [12:0] xu, yu;
    logic [13:0] au;
    logic signed [12:0] x0, y0, ux0, uy0;
    logic signed [11:0] cx0, cy0;
    int n_chk = 0;
    int n_fail = 0;

    cordic_rotator #(.FRAC_IN(F), .FRAC_OUT(FO), .SIGNED_IO(1), .COMPENSATE(0)) u_dut (
        .clk(clk), .rst_n(rst_n), .en(en), .x_in(xs), .y_in(ys), .ang_in(as),
        .x_out(x0), .y_out(y0));
    cordic_rotator #(.FRAC_IN(F), .FRAC_OUT(FO), .SIGNED_IO(1), .COMPENSATE(1)) u_dut_cmp (
        .clk(clk), .rst_n(rst_n), .en(en), .x_in(xs), .y_in(ys), .ang_in(as),
        .x_out(cx0), .y_out(cy0));
    cordic_rotator #(.FRAC_IN(F), .FRAC_OUT(FO), .SIGNED_IO(0), .COMPENSATE(0)) u_dut_uns (
        .clk(clk), .rst_n(rst_n), .en(en), .x_in(xu), .y_in(yu), .ang_in(au),
        .x_out(ux0), .y_out(uy0));

    function automatic real mdl_x(real x, real y, real a, real g);
        return g * (x * $cos(a) - y * $sin(a)) * OSC;
    endfunction
    function automatic real mdl_y(real x, real y, real a, real g);
        return g * (x * $sin(a) + y * $cos(a)) * OSC;
    endfunction
    function automatic int iabs(int v);
        return (v < 0) ? -v : v;
    endfunction

    task automatic chk(input string req, input real got, input real expv);
        real d;
        n_chk++;
        d = got - expv;
        if (d < 0.0) d = -d;
        if (d > 1.0) begin
            n_fail++;
            $display("FAIL %s: got %0.3f expected %0.3f (output LSBs)", req, got, expv);
        end
    endtask

    task automatic chk_eq(input string req, input int got, input int expv);
        n_chk++;
        if (got != expv) begin
            n_fail++;
            $display("FAIL %s: got %0d expected %0d", req, got, expv);
        end
    endtask

    task automatic drive(input int x, input int y, input int a);
        xs = 14'(x); ys = 14'(y); as = 15'(a);
        xu = 13'(iabs(x)); yu = 13'(iabs(y)); au = 14'(iabs(a));
    endtask

    // checks all three instances against the real-valued model
    task automatic check_all(input string tag, input int x, input int y, input int a);
        real xr, yr, ar;
        xr = x / ONE; yr = y / ONE; ar = a / ONE;
        chk(tag, real'(x0), mdl_x(xr, yr, ar, KG));
        chk(tag, real'(y0), mdl_y(xr, yr, ar, KG));
        chk("R3", real'(cx0), mdl_x(xr, yr, ar, 1.0));
        chk("R3", real'(cy0), mdl_y(xr, yr, ar, 1.0));
        xr = iabs(x) / ONE; yr = iabs(y) / ONE; ar = iabs(a) / ONE;
        chk("R9", real'(ux0), mdl_x(xr, yr, ar, KG));
        chk("R9", real'(uy0), mdl_y(xr, yr, ar, KG));
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        n_chk++;
        n_fail++;
        $display("FAIL watchdog: got timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        rst_n = 1'b0; en = 1'b1;
        drive(4096, 4096, 3217);
        repeat (3) @(posedge clk);
        @(negedge clk);
        // R8: reset state
        chk_eq("R8", int'(x0), 0);  chk_eq("R8", int'(y0), 0);
        chk_eq("R8", int'(cx0), 0); chk_eq("R8", int'(ux0), 0);
        rst_n = 1'b1;

        // vector table: R1/R2 ordinary, R4 beyond pi/2, R5 corners
        for (int v = 0; v < NV; v++) begin
            string tag;
            @(negedge clk);
            drive(VX[v], VY[v], VA[v]);
            repeat (LAT) @(posedge clk);
            @(negedge clk);
            if (iabs(VX[v]) == 4096 && iabs(VY[v]) == 4096) tag = "R5";
            else if (iabs(VA[v]) > 6434) tag = "R4";
            else tag = "R1/R2";
            check_all(tag, VX[v], VY[v], VA[v]);
        end

        // R7: freeze with en low while the inputs change
        @(negedge clk);
        drive(2048, 1024, 9000);
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        en = 1'b0;
        drive(-4096, 4096, -12868);
        repeat (40) @(posedge clk);
        @(negedge clk);
        check_all("R7", 2048, 1024, 9000);
        en = 1'b1;
        repeat (LAT) @(posedge clk);
        @(negedge clk);
        check_all("R7", -4096, 4096, -12868);

        // R6: flush with zeros, then three back-to-back vectors
        drive(0, 0, 0);
        repeat (LAT + 2) @(posedge clk);
        @(negedge clk);
        drive(4096, 0, 0);
        @(posedge clk); @(negedge clk);
        drive(0, 4096, 0);
        @(posedge clk); @(negedge clk);
        drive(-4096, 0, 0);
        repeat (LAT - 3) @(posedge clk);
        @(negedge clk);
        chk_eq("R6", int'(x0), 0);
        chk_eq("R6", int'(y0), 0);
        @(posedge clk); @(negedge clk);
        chk("R6", real'(x0), mdl_x(1.0, 0.0, 0.0, KG));
        @(posedge clk); @(negedge clk);
        chk("R6", real'(y0), mdl_y(0.0, 1.0, 0.0, KG));
        @(posedge clk); @(negedge clk);
        chk("R6", real'(x0), mdl_x(-1.0, 0.0, 0.0, KG));

        // R8: reset in mid-run clears the outputs on the next edge
        rst_n = 1'b0;
        @(posedge clk); @(negedge clk);
        chk_eq("R8", int'(x0), 0);
        chk_eq("R8", int'(cy0), 0);
        chk_eq("R8", int'(uy0), 0);
        rst_n = 1'b1;

        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end
endmodule